// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Sequencer

This block sits on the controller side of an SDRAM interface and owns the command pins whenever the memory is not in normal access. After reset it keeps the clock enable low for the power-up settling time. It then raises the clock enable and brings the device up with this command order: precharge of every bank, a programmable number of auto refreshes, a load of the mode register, and a load of the extended mode register. Between any two commands it inserts the minimum gap, in clocks, that the timing parameters require.

Once the device is initialized, the block counts the average refresh interval and keeps a count of refreshes that are owed, up to eight. It raises a request flag while any refresh is owed. The access scheduler answers with a grant once all banks are idle, and the sequencer then issues one auto refresh for each grant it accepts. A deep power-down request can be taken only from idle, and never while the owed count is being drained from its ceiling. When the request is released, the block raises the clock enable, waits the full settling time, and runs the whole initialization again.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is asserted, and for PU_CYC = ceil(T_PWRUP_NS/CLK_NS) cycles after it is released, cke is 0 and the command is NOP. The command is the value {cs_n,ras_n,cas_n,we_n}, and NOP is 0111. During this time init_done and ref_req are both 0.
- R2: After the settling time, the block drives one NOP cycle with cke at 1. The cycle after that carries the precharge-all command: 0010 with addr bit 10 set and every other address and bank bit at 0.
- R3: Initialization issues commands in this order: precharge-all, two auto refreshes (0001), a mode load (0000, ba=00, addr=MODE_KEY), and an extended mode load (0000, ba=10, addr=EXT_KEY). Every cycle between commands carries NOP with ba and addr at zero.
- R4: The next command follows a precharge after max(2, ceil(tRP/tCK)) cycles, an auto refresh after max(2, ceil(tRFC/tCK)) cycles, and a mode load after tMRD cycles. init_done rises tMRD cycles after the extended mode load.
- R5: ref_req rises REFI_CYC = ceil(T_REFI_NS/CLK_NS) cycles after init_done rises. Each further REFI_CYC cycles adds one owed refresh, up to a ceiling of 8. ref_req is high exactly while the owed count is nonzero.
- R6: A ref_gnt seen in idle while a refresh is owed produces an auto refresh in the next cycle. A ref_gnt seen while nothing is owed leaves the command at NOP.
- R7: After an auto refresh, only NOP follows for the rest of the tRFC window, and each auto refresh lowers the owed count by one.
- R8: Once the owed count reaches 8, dpd_req is ignored (cke stays 1 and no power-down command appears) until the count has drained to zero. Granted refreshes are still served during this time.
- R9: dpd_req seen in idle outside the drain condition produces the power-down entry command 0110 with cke at 0 in the next cycle. From that cycle, init_done is 0. cke stays 0 while dpd_req is held.
- R10: When dpd_req is released, cke is 1 from the next cycle onward. PU_CYC NOP cycles follow, then the full sequence of R2 to R4, with the same spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Scheduler grant: all banks idle, refresh may go |
| dpd_req | input | 1 | Level request to stay in deep power-down |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank select |
| addr | output | ADDR_W | Multiplexed address / mode key |
| init_done | output | 1 | Device initialized; scheduler owns the bus |
| ref_req | output | 1 | At least one refresh is owed |

## Verification
Every result of this block arrives exactly one clock after the edge that samples its cause. A grant or power-down request seen in idle shows as a command on the next cycle. The release of dpd_req raises cke on the next cycle. An interval tick changes ref_req on the cycle after the tick edge. Each command then holds the bus to NOP for the computed gap. The bench's reference model moves forward on each rising edge from the same sampled inputs. It compares the pins and flags at every falling edge, so each expected value is matched against the cycle in which the design must show it.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [3:0] {
    ST_PWR_WAIT,
    ST_CKE_UP,
    ST_PRE,
    ST_PRE_WAIT,
    ST_AREF_I,
    ST_AREF_I_WAIT,
    ST_MRS,
    ST_MRS_WAIT,
    ST_EMRS,
    ST_EMRS_WAIT,
    ST_IDLE,
    ST_AREF,
    ST_AREF_WAIT,
    ST_DPD_ENTER,
    ST_DPD
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOADMODE = 4'b0000,
    CMD_AREF     = 4'b0001,
    CMD_PRE      = 4'b0010,
    CMD_DPD      = 4'b0110,
    CMD_NOP      = 4'b0111
  } sdr_cmd_e;

  function automatic int ns_to_clk(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int floor2(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)              cnt_d = ld_val;
    else if (cnt_q != '0) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sdr_refresh_tracker.sv
module sdr_refresh_tracker #(
  parameter int REFI_CYC = 3120,
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dec,
  output logic pend_nz,
  output logic drain
);

  localparam int IW = $clog2(REFI_CYC + 1);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [IW-1:0] ival_q, ival_d;
  logic [PW-1:0] pend_q, pend_d;
  logic          drain_q, drain_d;
  logic          tick;

  assign tick = en && (ival_q == IW'(REFI_CYC - 1));

  always_comb begin
    ival_d  = ival_q;
    pend_d  = pend_q;
    drain_d = drain_q;
    if (!en) begin
      ival_d  = '0;
      pend_d  = '0;
      drain_d = 1'b0;
    end else begin
      ival_d = tick ? '0 : ival_q + IW'(1);
      case ({tick, dec})
        2'b10:   if (pend_q != PW'(MAX_PEND)) pend_d = pend_q + PW'(1);
        2'b01:   pend_d = pend_q - PW'(1);
        default: pend_d = pend_q;
      endcase
      if (pend_q == PW'(MAX_PEND)) drain_d = 1'b1;
      else if (pend_q == '0)       drain_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q  <= '0;
      pend_q  <= '0;
      drain_q <= 1'b0;
    end else begin
      ival_q  <= ival_d;
      pend_q  <= pend_d;
      drain_q <= drain_d;
    end
  end

  assign pend_nz = (pend_q != '0);
  assign drain   = (drain_q || (pend_q == PW'(MAX_PEND))) && pend_nz;

  // R5: owed count never passes its ceiling
  a_r5_pend_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PW'(MAX_PEND));

  // R5: at the ceiling a further tick does not wrap the count
  a_r5_pend_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pend_q == PW'(MAX_PEND) && !dec) |=> (pend_q == PW'(MAX_PEND)));

  // R7: a refresh is only retired when one is owed
  a_r7_dec_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> pend_nz);

endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int                 CLK_NS       = 5,
  parameter int                 T_PWRUP_NS   = 200000,
  parameter int                 T_RP_NS      = 15,
  parameter int                 T_RFC_NS     = 55,
  parameter int                 T_MRD_CLK    = 2,
  parameter int                 T_REFI_NS    = 15600,
  parameter int                 MAX_POSTPONE = 8,
  parameter int                 INIT_AREFS   = 2,
  parameter int                 BA_W         = 2,
  parameter int                 ADDR_W       = 12,
  parameter int                 AP_BIT       = 10,
  parameter logic [ADDR_W-1:0]  MODE_KEY     = 12'h032,
  parameter logic [ADDR_W-1:0]  EXT_KEY      = 12'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  input  logic              dpd_req,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              ref_req
);

  localparam int PU_CYC   = ns_to_clk(T_PWRUP_NS, CLK_NS);
  localparam int RP_CYC   = floor2(ns_to_clk(T_RP_NS, CLK_NS));
  localparam int RFC_CYC  = floor2(ns_to_clk(T_RFC_NS, CLK_NS));
  localparam int MRD_CYC  = floor2(T_MRD_CLK);
  localparam int REFI_CYC = ns_to_clk(T_REFI_NS, CLK_NS);
  localparam int TMR_MAX  = max_of(max_of(PU_CYC, RP_CYC), max_of(RFC_CYC, MRD_CYC));
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int ACW      = $clog2(INIT_AREFS + 1);
  localparam logic [BA_W-1:0] EXT_BA = BA_W'(2);

  seq_state_e       state_q, state_d;
  logic             wake_q, wake_d;
  logic [ACW-1:0]   acnt_q, acnt_d;
  logic             tmr_ld;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_done;
  logic             pend_nz;
  logic             drain;
  logic             aref_issue;
  sdr_cmd_e         cmd;

  sdr_wait_timer #(
    .W       (TMR_W),
    .RST_VAL (TMR_W'(PU_CYC - 1))
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (tmr_ld),
    .ld_val (tmr_val),
    .done   (tmr_done)
  );

  assign aref_issue = (state_q == ST_AREF);

  sdr_refresh_tracker #(
    .REFI_CYC (REFI_CYC),
    .MAX_PEND (MAX_POSTPONE)
  ) u_tracker (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (init_done),
    .dec     (aref_issue),
    .pend_nz (pend_nz),
    .drain   (drain)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    wake_d  = wake_q;
    acnt_d  = acnt_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    case (state_q)
      ST_PWR_WAIT:    if (tmr_done) state_d = ST_CKE_UP;
      ST_CKE_UP: begin
        wake_d  = 1'b0;
        state_d = ST_PRE;
      end
      ST_PRE: begin
        tmr_ld  = 1'b1;
        tmr_val = TMR_W'(RP_CYC - 2);
        acnt_d  = '0;
        state_d = ST_PRE_WAIT;
      end
      ST_PRE_WAIT:    if (tmr_done) state_d = ST_AREF_I;
      ST_AREF_I: begin
        tmr_ld  = 1'b1;
        tmr_val = TMR_W'(RFC_CYC - 2);
        state_d = ST_AREF_I_WAIT;
      end
      ST_AREF_I_WAIT: if (tmr_done) begin
        if (acnt_q == ACW'(INIT_AREFS - 1)) state_d = ST_MRS;
        else begin
          acnt_d  = acnt_q + ACW'(1);
          state_d = ST_AREF_I;
        end
      end
      ST_MRS: begin
        tmr_ld  = 1'b1;
        tmr_val = TMR_W'(MRD_CYC - 2);
        state_d = ST_MRS_WAIT;
      end
      ST_MRS_WAIT:    if (tmr_done) state_d = ST_EMRS;
      ST_EMRS: begin
        tmr_ld  = 1'b1;
        tmr_val = TMR_W'(MRD_CYC - 2);
        state_d = ST_EMRS_WAIT;
      end
      ST_EMRS_WAIT:   if (tmr_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (drain) begin
          if (ref_gnt && pend_nz) state_d = ST_AREF;
        end else if (dpd_req) begin
          state_d = ST_DPD_ENTER;
        end else if (ref_gnt && pend_nz) begin
          state_d = ST_AREF;
        end
      end
      ST_AREF: begin
        tmr_ld  = 1'b1;
        tmr_val = TMR_W'(RFC_CYC - 2);
        state_d = ST_AREF_WAIT;
      end
      ST_AREF_WAIT:   if (tmr_done) state_d = ST_IDLE;
      ST_DPD_ENTER:   state_d = ST_DPD;
      ST_DPD: if (!dpd_req) begin
        tmr_ld  = 1'b1;
        tmr_val = TMR_W'(PU_CYC - 1);
        wake_d  = 1'b1;
        state_d = ST_PWR_WAIT;
      end
      default:        state_d = ST_PWR_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWR_WAIT;
      wake_q  <= 1'b0;
      acnt_q  <= '0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
      acnt_q  <= acnt_d;
    end
  end

  // command and pin decode
  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    case (state_q)
      ST_PRE: begin
        cmd          = CMD_PRE;
        addr[AP_BIT] = 1'b1;
      end
      ST_AREF_I, ST_AREF: cmd = CMD_AREF;
      ST_MRS: begin
        cmd  = CMD_LOADMODE;
        addr = MODE_KEY;
      end
      ST_EMRS: begin
        cmd  = CMD_LOADMODE;
        ba   = EXT_BA;
        addr = EXT_KEY;
      end
      ST_DPD_ENTER: cmd = CMD_DPD;
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = 4'(cmd);
  assign cke       = !((state_q == ST_PWR_WAIT && !wake_q) ||
                       state_q == ST_DPD_ENTER || state_q == ST_DPD);
  assign init_done = (state_q == ST_IDLE) || (state_q == ST_AREF) ||
                     (state_q == ST_AREF_WAIT);
  assign ref_req   = init_done && pend_nz;

  // R1: nothing but NOP or power-down entry while cke is low
  a_r1_quiet_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd == CMD_NOP || cmd == CMD_DPD));

  // R4: a mode load is always followed by a NOP cycle
  a_r4_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOADMODE) |=> (cmd == CMD_NOP));

  // R6: a run-time auto refresh only when one is owed
  a_r6_aref_owed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_AREF && init_done) |-> pend_nz);

  // R7: tRFC window opens with NOP
  a_r7_aref_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_AREF) |=> (cmd == CMD_NOP));

  // R8: draining blocks power-down entry
  a_r8_drain_blocks_dpd: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && init_done) |=> (cmd != CMD_DPD));

  // R9: power-down entry carries cke low
  a_r9_dpd_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DPD) |-> !cke);

endmodule

// File: tb/test_sdram_init_refresh_seq.sv
module test_sdram_init_refresh_seq;

  localparam int CLKP  = 10;
  localparam int P_CYC = (2000 + CLKP - 1) / CLKP;  // 200
  localparam int RP    = 2;                         // ceil(15/10)
  localparam int RFC   = 6;                         // ceil(55/10)
  localparam int MRD   = 2;
  localparam int REFI  = (500 + CLKP - 1) / CLKP;   // 50
  localparam int MAXP  = 8;

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_AREF = 4'b0001;
  localparam logic [3:0] C_LOAD = 4'b0000;
  localparam logic [3:0] C_DPD  = 4'b0110;

  typedef struct packed {
    logic        cke;
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic        done;
  } exp_t;

  logic        clk, rst_n, ref_gnt, dpd_req;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done, ref_req;
  logic [1:0]  ba;
  logic [11:0] addr;

  sdram_init_refresh_seq #(
    .CLK_NS     (CLKP),
    .T_PWRUP_NS (2000),
    .T_REFI_NS  (500)
  ) i_sdram_init_refresh_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_gnt   (ref_gnt),
    .dpd_req   (dpd_req),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done),
    .ref_req   (ref_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    cyc    = 0;
  bit    finished = 0;

  // reference model state
  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  cur;
  string cur_tag;
  bit    model_ok = 0;
  int    mst;        // 0 script, 1 idle, 2 aref, 3 aref wait, 4 dpd entry, 5 dpd
  int    pend, ival, aw;
  bit    drain;

  function automatic exp_t mk(logic k, logic [3:0] c, logic [1:0] b, logic [11:0] a, logic d);
    exp_t e;
    e.cke = k; e.cmd = c; e.ba = b; e.addr = a; e.done = d;
    return e;
  endfunction

  function automatic void push(exp_t e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endfunction

  function automatic void load_script(bit waking);
    exp_q.delete();
    tag_q.delete();
    for (int i = 0; i < P_CYC; i++)
      push(mk(waking, C_NOP, 2'b00, 12'h000, 1'b0), waking ? "R10" : "R1");
    push(mk(1'b1, C_NOP, 2'b00, 12'h000, 1'b0), "R2");
    push(mk(1'b1, C_PRE, 2'b00, 12'h400, 1'b0), "R2");
    for (int i = 0; i < RP - 1; i++) push(mk(1'b1, C_NOP, 2'b00, 12'h000, 1'b0), "R4");
    for (int r = 0; r < 2; r++) begin
      push(mk(1'b1, C_AREF, 2'b00, 12'h000, 1'b0), "R3");
      for (int i = 0; i < RFC - 1; i++) push(mk(1'b1, C_NOP, 2'b00, 12'h000, 1'b0), "R4");
    end
    push(mk(1'b1, C_LOAD, 2'b00, 12'h032, 1'b0), "R3");
    for (int i = 0; i < MRD - 1; i++) push(mk(1'b1, C_NOP, 2'b00, 12'h000, 1'b0), "R4");
    push(mk(1'b1, C_LOAD, 2'b10, 12'h000, 1'b0), "R3");
    for (int i = 0; i < MRD - 1; i++) push(mk(1'b1, C_NOP, 2'b00, 12'h000, 1'b0), "R4");
  endfunction

  function automatic void take();
    cur     = exp_q.pop_front();
    cur_tag = tag_q.pop_front();
  endfunction

  function automatic void setc(logic k, logic [3:0] c, logic d, string t);
    cur     = mk(k, c, 2'b00, 12'h000, d);
    cur_tag = t;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      load_script(1'b0);
      take();
      mst = 0; pend = 0; ival = 0; drain = 0; aw = 0;
      model_ok = 1;
    end else if (model_ok) begin
      bit was_done, deff, tick, dec;
      int old_pend;
      was_done = cur.done;
      deff     = (drain || pend == MAXP) && pend > 0;
      tick     = was_done && (ival == REFI - 1);
      dec      = (mst == 2);
      old_pend = pend;
      case (mst)
        0: if (exp_q.size() > 0) take();
           else begin mst = 1; setc(1, C_NOP, 1, "R4"); end
        1: begin
          if (deff) begin
            if (ref_gnt && pend > 0) begin mst = 2; setc(1, C_AREF, 1, "R6"); end
            else setc(1, C_NOP, 1, dpd_req ? "R8" : "R6");
          end else if (dpd_req) begin
            mst = 4; setc(0, C_DPD, 0, "R9");
          end else if (ref_gnt && pend > 0) begin
            mst = 2; setc(1, C_AREF, 1, "R6");
          end else setc(1, C_NOP, 1, "R6");
        end
        2: begin mst = 3; aw = RFC - 1; setc(1, C_NOP, 1, "R7"); end
        3: begin
          aw--;
          if (aw == 0) mst = 1;
          setc(1, C_NOP, 1, "R7");
        end
        4: begin mst = 5; setc(0, C_NOP, 0, "R9"); end
        default: begin
          if (!dpd_req) begin load_script(1'b1); take(); mst = 0; end
          else setc(0, C_NOP, 0, "R9");
        end
      endcase
      if (was_done) begin
        ival = tick ? 0 : ival + 1;
        if (tick && !dec) begin
          if (pend < MAXP) pend++;
        end else if (!tick && dec) pend--;
        if (old_pend == MAXP) drain = 1;
        else if (old_pend == 0) drain = 0;
      end else begin
        ival = 0; pend = 0; drain = 0;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (model_ok && !finished) begin
      exp_t got;
      logic exp_req;
      got = mk(cke, {cs_n, ras_n, cas_n, we_n}, ba, addr, init_done);
      n_chk++;
      if (got !== cur) begin
        n_fail++;
        $display("FAIL %s cycle %0d: got cke=%b cmd=%b ba=%b addr=%h done=%b, expected cke=%b cmd=%b ba=%b addr=%h done=%b",
                 cur_tag, cyc, got.cke, got.cmd, got.ba, got.addr, got.done,
                 cur.cke, cur.cmd, cur.ba, cur.addr, cur.done);
      end
      exp_req = cur.done && (pend > 0);
      n_chk++;
      if (ref_req !== exp_req) begin
        n_fail++;
        $display("FAIL R5 cycle %0d: ref_req got %b expected %b (owed %0d)", cyc, ref_req, exp_req, pend);
      end
    end
  end

  task automatic wait_done(input bit level, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (init_done == level) return;
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ref_gnt = 1'b0; dpd_req = 1'b0;
    repeat (5) @(negedge clk);          // R1: reset-state compare
    rst_n = 1'b1;
    wait_done(1'b1, 400);               // R1..R4 init sequence
    repeat (60) @(negedge clk);         // R5: request after REFI
    ref_gnt = 1'b1;                     // R6: single grant
    @(negedge clk);
    ref_gnt = 1'b0;
    repeat (15) @(negedge clk);
    ref_gnt = 1'b1;                     // R6: grant with nothing owed
    @(negedge clk);
    ref_gnt = 1'b0;
    repeat (520) @(negedge clk);        // R5: owed count reaches ceiling
    dpd_req = 1'b1;                     // R8: ignored while draining
    repeat (30) @(negedge clk);
    ref_gnt = 1'b1;                     // R7/R8: drain, then R9 entry
    wait_done(1'b0, 300);
    ref_gnt = 1'b0;
    repeat (20) @(negedge clk);         // R9: cke held low
    dpd_req = 1'b0;                     // R10: wake and re-init
    wait_done(1'b1, 400);
    repeat (55) @(negedge clk);
    ref_gnt = 1'b1;                     // R6/R7: continuous grant
    repeat (150) @(negedge clk);
    ref_gnt = 1'b0;
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule